// File: doc/BRIEF.md
# PHY Test-Port Programming Sequencer

This block drives the serial test-configuration port of a physical-layer transceiver. The port has a test clock, a test enable, an 8-bit test data bus and a test clear line. Next to the port, the block owns the PHY power-up controls: an active-low shutdown, an active-low reset, a 2-bit lane-count field, a lane-clock enable and a PLL force bit. A host loads an operation code, a register code, a byte count, up to four data bytes and a hold count, then pulses `start`. The block replays the matching pin sequence by itself. It reports `busy` while the sequence runs and pulses `done` when it ends.

There are three operations. A register write sends the code and then the data bytes. The code phase keeps test enable high and is latched on a falling test clock. The data phase keeps test enable low and is latched on rising test clock edges. An init operation pulses test clear while it holds the PHY in shutdown and reset. A bring-up operation sets the lane field and then releases the PHY step by step. Each pin change is one step, and every step lasts the hold count in system clocks, so the PHY's setup and hold margins can be set by the host.

Top module: `phy_testport_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every port output is 0, including `busy` and `done`.
- R2: Operation code 0 (register write) first runs five steps in this order: test clock high, `code` placed on the test data bus, test enable high, test clock low, test enable low. Step i applies at the accept edge plus i times the hold count.
- R3: In a register write, each data byte takes three steps in order: test clock low, the byte on the test data bus, test clock high. Test enable stays low throughout. Byte k is `data[8k+7:8k]`, and bytes go out in the order k = 0, 1, and so on.
- R4: The effective byte count is `byte_count`, with 0 treated as 1 and any value above 4 treated as 4.
- R5: Operation code 1 (init) takes two steps. The first drives test clear high and drives shutdown, reset, the lane field, the lane-clock enable and the PLL force all low. The second drives test clear low. Test clock, enable and data keep their values.
- R6: Operation code 2 (bring-up) takes five steps in order: lane field set to 3, lane-clock enable high, PLL force high, shutdown released (high), reset released (high).
- R7: Every step lasts `hold_cycles` system clocks, with 0 treated as 1. The value is captured when the operation is accepted, and later changes to the input do not affect that operation.
- R8: `busy` rises at the accept edge. After N steps of hold H, `done` is high for exactly one cycle starting at the accept edge plus N·H, and `busy` falls at that same edge.
- R9: A `start` while `busy` is high is ignored, and so is a `start` with operation code 3. Neither changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | Operation: 0 write, 1 init, 2 bring-up, 3 reserved |
| code | input | 8 | Register code for a write |
| byte_count | input | 3 | Number of data bytes (clamped to 1..4) |
| data | input | 32 | Data bytes, byte k at bits 8k+7:8k |
| hold_cycles | input | 8 | System clocks per step (0 acts as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| tp_clk | output | 1 | Test clock to the PHY |
| tp_en | output | 1 | Test enable to the PHY |
| tp_din | output | 8 | Test data bus to the PHY |
| tp_clr | output | 1 | Test clear to the PHY |
| phy_shutdown_n | output | 1 | PHY shutdown, low = shut down |
| phy_reset_n | output | 1 | PHY reset, low = in reset |
| lane_cnt | output | 2 | Lane-count field |
| lane_clk_en | output | 1 | Lane clock enable |
| pll_force | output | 1 | Force PLL on |

## Verification
Each step's pin values become visible one register after the edge that enters the step. Step i therefore appears in cycles i·H through i·H+H−1 after the accept edge, and `done` appears in cycle N·H. The bench raises `start` on a falling edge, counts falling edges from the accept edge, and compares the whole output vector together with `busy`/`done` on every cycle of every step. It then checks that `done` is high on cycle N·H and low again on the next cycle. For ignored requests, the outputs and `busy` are compared on the cycles after the strobe against the values held before it.

// File: rtl/phytp_pkg.sv
package phytp_pkg;

    parameter int unsigned TP_DIN_W  = 8;
    parameter int unsigned TP_LANE_W = 2;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_INIT   = 2'd1,
        OP_BRINGUP = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_C_CLK_HI,
        ST_C_CODE,
        ST_C_EN_HI,
        ST_C_CLK_LO,
        ST_C_EN_LO,
        ST_D_CLK_LO,
        ST_D_BYTE,
        ST_D_CLK_HI,
        ST_I_CLR_HI,
        ST_I_CLR_LO,
        ST_B_LANES,
        ST_B_LCLK,
        ST_B_PLL,
        ST_B_SDN,
        ST_B_RST
    } step_e;

    typedef struct packed {
        logic                 tclk;
        logic                 ten;
        logic [TP_DIN_W-1:0]  tdin;
        logic                 tclr;
        logic                 sdn_n;
        logic                 rst_n;
        logic [TP_LANE_W-1:0] lanes;
        logic                 lclk;
        logic                 pll;
    } port_t;

endpackage

// File: rtl/phytp_hold_timer.sv
module phytp_hold_timer #(
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              step_end
);

    logic [HOLD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the step ends on the edge that would take the counter from 1 to 0
    assign step_end = (cnt_q == HOLD_W'(1));

endmodule

// File: rtl/phytp_step_ctrl.sv
module phytp_step_ctrl
    import phytp_pkg::*;
#(
    parameter int unsigned HOLD_W    = 8,
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              step_end,
    output logic              accept,
    output logic              enter,
    output step_e             nxt_step,
    output logic [IDX_W-1:0]  nxt_idx,
    output logic [HOLD_W-1:0] nxt_hold,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        step_e             step;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [HOLD_W-1:0] hold;
        logic              done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [CNT_W-1:0] eff_cnt;
    logic [CNT_W-1:0] eff_m1;
    logic             running;

    // R4: clamp the requested byte count into 1..MAX_BYTES
    always_comb begin
        if (byte_count == '0)                     eff_cnt = CNT_W'(1);
        else if (byte_count > CNT_W'(MAX_BYTES))  eff_cnt = CNT_W'(MAX_BYTES);
        else                                      eff_cnt = byte_count;
        eff_m1 = eff_cnt - 1'b1;
    end

    assign running = (s_q.step != ST_IDLE);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        if (!running) begin
            if (start && (op_e'(op) != OP_RSVD)) begin
                accept   = 1'b1;
                s_d.idx  = '0;
                s_d.last = eff_m1[IDX_W-1:0];
                s_d.hold = (hold_cycles == '0) ? HOLD_W'(1) : hold_cycles;
                case (op_e'(op))
                    OP_WRITE:   s_d.step = ST_C_CLK_HI;
                    OP_INIT:    s_d.step = ST_I_CLR_HI;
                    default:    s_d.step = ST_B_LANES;
                endcase
            end
        end else if (step_end) begin
            case (s_q.step)
                ST_C_CLK_HI: s_d.step = ST_C_CODE;
                ST_C_CODE:   s_d.step = ST_C_EN_HI;
                ST_C_EN_HI:  s_d.step = ST_C_CLK_LO;
                ST_C_CLK_LO: s_d.step = ST_C_EN_LO;
                ST_C_EN_LO:  s_d.step = ST_D_CLK_LO;
                ST_D_CLK_LO: s_d.step = ST_D_BYTE;
                ST_D_BYTE:   s_d.step = ST_D_CLK_HI;
                ST_D_CLK_HI: begin
                    if (s_q.idx == s_q.last) begin
                        s_d.step = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.idx  = s_q.idx + 1'b1;
                        s_d.step = ST_D_CLK_LO;
                    end
                end
                ST_I_CLR_HI: s_d.step = ST_I_CLR_LO;
                ST_B_LANES:  s_d.step = ST_B_LCLK;
                ST_B_LCLK:   s_d.step = ST_B_PLL;
                ST_B_PLL:    s_d.step = ST_B_SDN;
                ST_B_SDN:    s_d.step = ST_B_RST;
                default: begin
                    // ST_I_CLR_LO and ST_B_RST close their operations
                    s_d.step = ST_IDLE;
                    s_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{step: ST_IDLE, idx: '0, last: '0, hold: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign enter    = (s_d.step != ST_IDLE) && (accept || (running && step_end));
    assign nxt_step = s_d.step;
    assign nxt_idx  = s_d.idx;
    assign nxt_hold = s_d.hold;
    assign busy     = running;
    assign done     = s_q.done;

endmodule

// File: rtl/phytp_port_drive.sv
module phytp_port_drive
    import phytp_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned IDX_W     = 2,
    parameter int unsigned LANE_VAL  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic [TP_DIN_W-1:0]           code_in,
    input  logic [MAX_BYTES*TP_DIN_W-1:0] data_in,
    input  logic                          enter,
    input  step_e                         nxt_step,
    input  logic [IDX_W-1:0]              nxt_idx,
    output port_t                         port
);

    typedef struct packed {
        port_t                         port;
        logic [TP_DIN_W-1:0]           code;
        logic [MAX_BYTES*TP_DIN_W-1:0] data;
    } drv_t;

    drv_t r_d, r_q;

    logic [TP_DIN_W-1:0] stage_byte [MAX_BYTES];

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bytes
        assign stage_byte[g] = r_q.data[g*TP_DIN_W +: TP_DIN_W];
    end

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.code = code_in;
            r_d.data = data_in;
        end
        if (enter) begin
            case (nxt_step)
                ST_C_CLK_HI: r_d.port.tclk = 1'b1;
                ST_C_CODE:   r_d.port.tdin = r_q.code;
                ST_C_EN_HI:  r_d.port.ten  = 1'b1;
                ST_C_CLK_LO: r_d.port.tclk = 1'b0;
                ST_C_EN_LO:  r_d.port.ten  = 1'b0;
                ST_D_CLK_LO: r_d.port.tclk = 1'b0;
                ST_D_BYTE:   r_d.port.tdin = stage_byte[nxt_idx];
                ST_D_CLK_HI: r_d.port.tclk = 1'b1;
                ST_I_CLR_HI: begin
                    r_d.port.tclr  = 1'b1;
                    r_d.port.sdn_n = 1'b0;
                    r_d.port.rst_n = 1'b0;
                    r_d.port.lanes = '0;
                    r_d.port.lclk  = 1'b0;
                    r_d.port.pll   = 1'b0;
                end
                ST_I_CLR_LO: r_d.port.tclr  = 1'b0;
                ST_B_LANES:  r_d.port.lanes = TP_LANE_W'(LANE_VAL);
                ST_B_LCLK:   r_d.port.lclk  = 1'b1;
                ST_B_PLL:    r_d.port.pll   = 1'b1;
                ST_B_SDN:    r_d.port.sdn_n = 1'b1;
                ST_B_RST:    r_d.port.rst_n = 1'b1;
                default:     r_d.port = r_q.port;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign port = r_q.port;

endmodule

// File: rtl/phy_testport_seq.sv
module phy_testport_seq
    import phytp_pkg::*;
#(
    parameter int unsigned HOLD_W    = 8,
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned LANE_VAL  = 3,
    localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int unsigned IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int unsigned DATA_W   = MAX_BYTES * TP_DIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic [TP_DIN_W-1:0]  code,
    input  logic [CNT_W-1:0]     byte_count,
    input  logic [DATA_W-1:0]    data,
    input  logic [HOLD_W-1:0]    hold_cycles,
    output logic                 busy,
    output logic                 done,
    output logic                 tp_clk,
    output logic                 tp_en,
    output logic [TP_DIN_W-1:0]  tp_din,
    output logic                 tp_clr,
    output logic                 phy_shutdown_n,
    output logic                 phy_reset_n,
    output logic [TP_LANE_W-1:0] lane_cnt,
    output logic                 lane_clk_en,
    output logic                 pll_force
);

    logic              accept;
    logic              enter;
    logic              step_end;
    step_e             nxt_step;
    logic [IDX_W-1:0]  nxt_idx;
    logic [HOLD_W-1:0] nxt_hold;
    port_t             port;

    phytp_step_ctrl #(
        .HOLD_W    (HOLD_W),
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op          (op),
        .byte_count  (byte_count),
        .hold_cycles (hold_cycles),
        .step_end    (step_end),
        .accept      (accept),
        .enter       (enter),
        .nxt_step    (nxt_step),
        .nxt_idx     (nxt_idx),
        .nxt_hold    (nxt_hold),
        .busy        (busy),
        .done        (done)
    );

    phytp_hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter),
        .load_val (nxt_hold),
        .step_end (step_end)
    );

    phytp_port_drive #(
        .MAX_BYTES (MAX_BYTES),
        .IDX_W     (IDX_W),
        .LANE_VAL  (LANE_VAL)
    ) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .code_in  (code),
        .data_in  (data),
        .enter    (enter),
        .nxt_step (nxt_step),
        .nxt_idx  (nxt_idx),
        .port     (port)
    );

    assign tp_clk         = port.tclk;
    assign tp_en          = port.ten;
    assign tp_din         = port.tdin;
    assign tp_clr         = port.tclr;
    assign phy_shutdown_n = port.sdn_n;
    assign phy_reset_n    = port.rst_n;
    assign lane_cnt       = port.lanes;
    assign lane_clk_en    = port.lclk;
    assign pll_force      = port.pll;

endmodule

// File: rtl/phytp_checker.sv
module phytp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       tp_clk,
    input logic       tp_en,
    input logic [7:0] tp_din,
    input logic       tp_clr,
    input logic       phy_shutdown_n,
    input logic       phy_reset_n
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8

    AST_CODE_EN_DROP_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tp_en) |-> !tp_clk); // R2

    AST_DATA_RISE_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tp_clk) |-> (!tp_en && $stable(tp_din))); // R3

    AST_CLR_HOLDS_PHY: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clr |-> (!phy_shutdown_n && !phy_reset_n)); // R5

    AST_RESET_AFTER_SDN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_reset_n) |-> phy_shutdown_n); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(tp_clk) && $stable(tp_en) && $stable(tp_din))); // R9

endmodule

bind phy_testport_seq phytp_checker u_phytp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .tp_clk         (tp_clk),
    .tp_en          (tp_en),
    .tp_din         (tp_din),
    .tp_clr         (tp_clr),
    .phy_shutdown_n (phy_shutdown_n),
    .phy_reset_n    (phy_reset_n)
);

// File: tb/phy_testport_seq_bench.sv
module phy_testport_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [7:0]  code = 8'h00;
    logic [2:0]  byte_count = 3'd1;
    logic [31:0] data = 32'h0;
    logic [7:0]  hold_cycles = 8'd1;
    logic        busy, done, tp_clk, tp_en, tp_clr, phy_shutdown_n, phy_reset_n;
    logic        lane_clk_en, pll_force;
    logic [7:0]  tp_din;
    logic [1:0]  lane_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // expected pin state, kept by the bench
    logic       e_clk, e_en, e_clr, e_sdn, e_rst, e_lclk, e_pll;
    logic [7:0] e_din;
    logic [1:0] e_lanes;
    int         cur_hold;
    bit         inject;
    int         op_cyc;

    always #10 clk = ~clk;

    phy_testport_seq u_phy_testport_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .code(code),
        .byte_count(byte_count), .data(data), .hold_cycles(hold_cycles),
        .busy(busy), .done(done), .tp_clk(tp_clk), .tp_en(tp_en),
        .tp_din(tp_din), .tp_clr(tp_clr), .phy_shutdown_n(phy_shutdown_n),
        .phy_reset_n(phy_reset_n), .lane_cnt(lane_cnt),
        .lane_clk_en(lane_clk_en), .pll_force(pll_force)
    );

    function automatic logic [16:0] obs_vec();
        return {tp_clk, tp_en, tp_din, tp_clr, phy_shutdown_n, phy_reset_n,
                lane_cnt, lane_clk_en, pll_force};
    endfunction

    function automatic logic [16:0] exp_vec();
        return {e_clk, e_en, e_din, e_clr, e_sdn, e_rst, e_lanes, e_lclk, e_pll};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_exp();
        {e_clk, e_en, e_din, e_clr, e_sdn, e_rst, e_lanes, e_lclk, e_pll} = '0;
    endtask

    // one step: compare every cycle of it, optionally poke start mid-step
    task automatic run_step(input string req);
        for (int c = 0; c < cur_hold; c++) begin
            chk(32'(obs_vec()), 32'(exp_vec()), req);
            chk({30'd0, busy, done}, 32'b10, {req, " R8 busy"});
            if (inject && op_cyc == 1) begin
                start = 1'b1; op = 2'd2; hold_cycles = 8'd1;
            end else if (inject && op_cyc == 2) begin
                start = 1'b0;
            end
            op_cyc++;
            @(negedge clk);
        end
    endtask

    task automatic launch(input logic [1:0] o, input logic [7:0] c, input logic [2:0] n,
                          input logic [31:0] d, input logic [7:0] h);
        op = o; code = c; byte_count = n; data = d; hold_cycles = h;
        start = 1'b1;
        cur_hold = (h == 8'd0) ? 1 : int'(h);
        op_cyc = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_op(input string req);
        chk({30'd0, busy, done}, 32'b01, {req, " R8 done"});
        chk(32'(obs_vec()), 32'(exp_vec()), {req, " R8 held"});
        @(negedge clk);
        chk({30'd0, busy, done}, 32'b00, {req, " R8 done drop"});
        inject = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_exp();
        chk(32'(obs_vec()), 32'(exp_vec()), "R1 pins in reset");
        chk({30'd0, busy, done}, 32'b00, "R1 status in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(obs_vec()), 32'(exp_vec()), "R1 pins after reset");
        chk({30'd0, busy, done}, 32'b00, "R1 status after reset");
    endtask

    task automatic t_init(input logic [7:0] h);
        launch(2'd1, 8'h00, 3'd1, 32'h0, h);
        e_clr = 1'b1; e_sdn = 1'b0; e_rst = 1'b0; e_lanes = 2'd0; e_lclk = 1'b0; e_pll = 1'b0;
        run_step("R5 clear high");
        e_clr = 1'b0;
        run_step("R5 clear low");
        finish_op("R5");
    endtask

    task automatic t_bringup(input logic [7:0] h);
        launch(2'd2, 8'h00, 3'd1, 32'h0, h);
        e_lanes = 2'd3; run_step("R6 lane field 3");
        e_lclk = 1'b1;  run_step("R6 lane clock");
        e_pll = 1'b1;   run_step("R6 pll force");
        e_sdn = 1'b1;   run_step("R6 shutdown release");
        e_rst = 1'b1;   run_step("R6 reset release");
        finish_op("R6");
    endtask

    task automatic t_write(input logic [7:0] c, input logic [2:0] n, input logic [31:0] d,
                           input logic [7:0] h, input bit poke, input string tag);
        int nb;
        nb = (n == 3'd0) ? 1 : ((n > 3'd4) ? 4 : int'(n));
        inject = poke;
        launch(2'd0, c, n, d, h);
        e_clk = 1'b1; run_step({tag, " R2 clk high"});
        e_din = c;    run_step({tag, " R2 code"});
        e_en = 1'b1;  run_step({tag, " R2 en high"});
        e_clk = 1'b0; run_step({tag, " R2 clk low"});
        e_en = 1'b0;  run_step({tag, " R2 en low"});
        for (int b = 0; b < nb; b++) begin
            e_clk = 1'b0;         run_step({tag, " R3 clk low"});
            e_din = d[8*b +: 8];  run_step({tag, " R3 byte R4"});
            e_clk = 1'b1;         run_step({tag, " R3 clk high"});
        end
        finish_op({tag, " R4"});
    endtask

    task automatic t_reserved();
        op = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk({30'd0, busy, done}, 32'b00, "R9 reserved op busy");
            chk(32'(obs_vec()), 32'(exp_vec()), "R9 reserved op pins");
            @(negedge clk);
        end
    endtask

    initial begin
        inject = 1'b0;
        cur_hold = 1;
        clear_exp();
        @(negedge clk);
        t_reset();
        t_init(8'd2);
        t_write(8'hA5, 3'd1, 32'h0000_003C, 8'd1, 1'b0, "w1");
        t_write(8'h5E, 3'd4, 32'h1122_3344, 8'd3, 1'b1, "w4 busy-poke R7 R9");
        hold_cycles = 8'd1;
        t_write(8'h0F, 3'd0, 32'hDEAD_BE81, 8'd0, 1'b0, "w0 clamp R7");
        t_write(8'hC3, 3'd7, 32'hA1B2_C3D4, 8'd2, 1'b0, "w7 clamp");
        t_bringup(8'd2);
        t_reserved();
        t_init(8'd1);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule